// File: doc/BRIEF.md
# Configuration Power-Up and Start-Up Sequencer

This block is the control state machine that takes a programmable logic device from supply ramp to user operation. It waits until both the I/O supply and the core supply report good. It then clears configuration memory for a fixed, parameterised number of cycles. Next it hands the shared open-drain INIT line back to the board and opens a window in which configuration frames may be loaded. When the frame loader reports completion, the block compares the calculated CRC with the expected CRC. It then either runs a three-step start-up or parks in an error state.

INIT is a two-way handshake. The block pulls the line low while clearing and after a CRC error. Any external agent holding the line low keeps the block from leaving the clear phase, because the block only moves on once it senses the line high through a two-flop synchroniser. The mode pins are captured in the cycle the block recognises the line's low-to-high transition. PROGRAM (active low) restarts the sequence from any state, and losing either supply drops the block back to its powered-off state.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: While either `vcco_ok` or `vccint_ok` is low, `init_pull` is 1 and `done_o`, `load_en`, `io_active` and `gsr_release` are 0. No clear phase elapses, however long a single supply has been good.
- R2: Once both supplies are good, the block enters the clear phase with `init_pull`=1 (1 means drive INIT low) and `done_o`=0. The clear phase lasts exactly CLR_CYCLES clock cycles, counted from the first cycle in which `prog_n` is high.
- R3: After the clear phase, `init_pull` goes to 0. `load_en` rises exactly three cycles later if the sensed INIT line is high: two synchroniser stages plus one state update.
- R4: Holding `prog_n` low keeps the block in the clear phase. Holding the INIT line low externally after release keeps `load_en` at 0. `load_en` rises three cycles after the line goes high.
- R5: `mode_latched` takes the value of `mode_pins` in the cycle `load_en` rises, and keeps that value while the pins change afterwards.
- R6: A `load_done` pulse while `load_en` is 0 has no effect on the sequence.
- R7: A `load_done` pulse with `load_en`=1 and `crc_calc`≠`crc_expect` (a mismatch in any bit) leads, one cycle later, to `init_pull`=1 and `done_o`=0. This state is held, ignoring further `load_done` pulses, until `prog_n` goes low or a supply is lost.
- R8: A `load_done` pulse with `load_en`=1 and matching CRCs sets `done_o` on the next cycle, then `io_active` on the following cycle, then `gsr_release` on the cycle after that. All three then stay high, which is user operation.
- R9: `prog_n` low in any state returns the block to the clear phase on the next cycle. Losing a supply in any state returns it to the powered-off state. In both cases `done_o`, `load_en`, `io_active` and `gsr_release` are 0.
- R10: While `rst_n` is low, `init_pull`=1, the other single-bit outputs are 0 and `mode_latched` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| vcco_ok | input | 1 | I/O supply good |
| vccint_ok | input | 1 | Core supply good |
| prog_n | input | 1 | Active-low reconfiguration request |
| init_in | input | 1 | Sensed level of the shared INIT line (asynchronous) |
| mode_pins | input | MODE_W | Configuration mode pins |
| load_done | input | 1 | Frame loader finished strobe |
| crc_calc | input | CRC_W | CRC computed over the loaded frames |
| crc_expect | input | CRC_W | CRC carried in the configuration stream |
| init_pull | output | 1 | 1 = drive INIT low, 0 = release it |
| done_o | output | 1 | DONE level |
| mode_latched | output | MODE_W | Mode pins captured when INIT was seen high |
| load_en | output | 1 | Frame loading window open |
| io_active | output | 1 | User I/Os enabled |
| gsr_release | output | 1 | Global set/reset released |

## Verification
The bench targets the clear timing: a counter that is off by one would release INIT one cycle early or late. It also targets the PROGRAM stretch: a clear counter that keeps running while PROGRAM is held would release INIT early. An external hold on INIT after release must keep the load window shut. A design that skipped the synchroniser or sampled the raw line would open the window too soon or latch stale mode pins. A CRC mismatch confined to the upper lane, `load_done` pulses in the error and release states, and supply loss from user operation are also covered. A wrong lane reduction would start up on bad data, and a leaky error state would recover without PROGRAM.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

   typedef enum logic [2:0] {
      ST_OFF     = 3'd0,
      ST_CLEAR   = 3'd1,
      ST_RELEASE = 3'd2,
      ST_LOAD    = 3'd3,
      ST_DONE_HI = 3'd4,
      ST_IO_ON   = 3'd5,
      ST_USER    = 3'd6,
      ST_ERR     = 3'd7
   } cfg_state_t;

   typedef struct packed {
      logic pull;
      logic done;
      logic load;
      logic io;
      logic gsr;
   } cfg_outs_t;

   function automatic cfg_outs_t outs_of(cfg_state_t s);
      cfg_outs_t o;
      o = '0;
      case (s)
         ST_OFF, ST_CLEAR, ST_ERR: o.pull = 1'b1;
         ST_LOAD:                  o.load = 1'b1;
         ST_DONE_HI:               o.done = 1'b1;
         ST_IO_ON:                 begin o.done = 1'b1; o.io = 1'b1; end
         ST_USER:                  begin o.done = 1'b1; o.io = 1'b1; o.gsr = 1'b1; end
         default:                  o = '0;
      endcase
      return o;
   endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin
      if (STAGES < 2) $fatal(1, "cfg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_clear_timer.sv
module cfg_clear_timer #(
   parameter int CLR_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CNT_W = (CLR_CYCLES > 2) ? $clog2(CLR_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CLR_CYCLES - 1);

   initial begin
      if (CLR_CYCLES < 2) $fatal(1, "cfg_clear_timer: CLR_CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (!run)        cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign expired = run && (cnt_q == LAST);

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R2
   cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0));
endmodule

// File: rtl/cfg_crc_match.sv
module cfg_crc_match #(
   parameter int CRC_W  = 32,
   parameter int LANE_W = 8
) (
   input  logic [CRC_W-1:0] calc,
   input  logic [CRC_W-1:0] expect_v,
   output logic             match
);
   localparam int NLANE = (CRC_W + LANE_W - 1) / LANE_W;
   localparam int TOT_W = NLANE * LANE_W;

   initial begin
      if (CRC_W < 1)  $fatal(1, "cfg_crc_match: CRC_W must be positive");
      if (LANE_W < 1) $fatal(1, "cfg_crc_match: LANE_W must be positive");
   end

   logic [TOT_W-1:0] pa, pb;
   logic [NLANE-1:0] lane_eq;

   assign pa = TOT_W'(calc);
   assign pb = TOT_W'(expect_v);

   genvar l;
   generate
      for (l = 0; l < NLANE; l++) begin : g_lane
         assign lane_eq[l] = ~|(pa[l*LANE_W +: LANE_W] ^ pb[l*LANE_W +: LANE_W]);
      end
   endgenerate

   assign match = &lane_eq;
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
   import cfg_seq_pkg::*;
#(
   parameter int MODE_W      = 3,
   parameter int CRC_W       = 32,
   parameter int LANE_W      = 8,
   parameter int CLR_CYCLES  = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vcco_ok,
   input  logic              vccint_ok,
   input  logic              prog_n,
   input  logic              init_in,
   input  logic [MODE_W-1:0] mode_pins,
   input  logic              load_done,
   input  logic [CRC_W-1:0]  crc_calc,
   input  logic [CRC_W-1:0]  crc_expect,
   output logic              init_pull,
   output logic              done_o,
   output logic [MODE_W-1:0] mode_latched,
   output logic              load_en,
   output logic              io_active,
   output logic              gsr_release
);
   initial begin
      if (MODE_W < 1) $fatal(1, "cfg_seq_ctrl: MODE_W must be positive");
   end

   cfg_state_t st_q, st_d;
   cfg_outs_t  outs;
   logic       pwr_ok, init_hi, clear_done, crc_ok, latch_mode;
   logic [MODE_W-1:0] mode_q;

   assign pwr_ok = vcco_ok && vccint_ok;

   cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (init_in),
      .q     (init_hi)
   );

   cfg_clear_timer #(.CLR_CYCLES(CLR_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     ((st_q == ST_CLEAR) && prog_n),
      .expired (clear_done)
   );

   cfg_crc_match #(.CRC_W(CRC_W), .LANE_W(LANE_W)) u_crc (
      .calc     (crc_calc),
      .expect_v (crc_expect),
      .match    (crc_ok)
   );

   always_comb begin
      st_d = st_q;
      if (!pwr_ok) begin
         st_d = ST_OFF;
      end else if (!prog_n) begin
         st_d = ST_CLEAR;
      end else begin
         case (st_q)
            ST_OFF:     st_d = ST_CLEAR;
            ST_CLEAR:   if (clear_done) st_d = ST_RELEASE;
            ST_RELEASE: if (init_hi) st_d = ST_LOAD;
            ST_LOAD:    if (load_done) st_d = crc_ok ? ST_DONE_HI : ST_ERR;
            ST_DONE_HI: st_d = ST_IO_ON;
            ST_IO_ON:   st_d = ST_USER;
            ST_USER:    st_d = ST_USER;
            ST_ERR:     st_d = ST_ERR;
            default:    st_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_OFF;
      else        st_q <= st_d;
   end

   assign latch_mode = (st_q == ST_RELEASE) && (st_d == ST_LOAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mode_q <= '0;
      else if (latch_mode) mode_q <= mode_pins;
   end

   assign outs         = outs_of(st_q);
   assign init_pull    = outs.pull;
   assign done_o       = outs.done;
   assign load_en      = outs.load;
   assign io_active    = outs.io;
   assign gsr_release  = outs.gsr;
   assign mode_latched = mode_q;

   // R1
   no_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(vcco_ok && vccint_ok) |=> (init_pull && !done_o && !load_en && !io_active && !gsr_release));

   // R3
   load_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |-> !init_pull);

   // R3
   load_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_en) |-> $past(init_hi));

   // R5
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_mode |=> $stable(mode_latched));

   // R7
   crc_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && load_done && !(crc_calc == crc_expect) && prog_n && vcco_ok && vccint_ok)
      |=> (init_pull && !done_o));

   // R8
   io_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(io_active) |-> (done_o && $past(done_o)));

   // R8
   gsr_after_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gsr_release) |-> $past(io_active));

   // R9
   prog_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_n |=> (init_pull && !done_o && !load_en && !io_active && !gsr_release));
endmodule

// File: tb/cfg_seq_ctrl_bench.sv
`timescale 1ns/1ps
module cfg_seq_ctrl_bench;
   localparam int MW = 3;
   localparam int CW = 16;
   localparam int N  = 8;

   localparam logic [4:0] O_PULL = 5'b10000;
   localparam logic [4:0] O_REL  = 5'b00000;
   localparam logic [4:0] O_LOAD = 5'b00100;
   localparam logic [4:0] O_D    = 5'b01000;
   localparam logic [4:0] O_DI   = 5'b01010;
   localparam logic [4:0] O_USER = 5'b01011;

   typedef struct {
      logic [4:0]    bits;
      logic [MW-1:0] mode;
      bit            chk_mode;
      string         req;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n, vcco_ok, vccint_ok, prog_n, ext_hold, load_done;
   logic [MW-1:0] mode_pins;
   logic [CW-1:0] crc_calc, crc_expect;
   logic init_in, init_pull, done_o, load_en, io_active, gsr_release;
   logic [MW-1:0] mode_latched;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   exp_t q[$];
   event mon_ev;

   always #2.5 clk = ~clk;

   assign init_in = !(init_pull || ext_hold);

   cfg_seq_ctrl #(.MODE_W(MW), .CRC_W(CW), .LANE_W(8), .CLR_CYCLES(N), .SYNC_STAGES(2)) u_cfg_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .vcco_ok(vcco_ok), .vccint_ok(vccint_ok), .prog_n(prog_n),
      .init_in(init_in), .mode_pins(mode_pins), .load_done(load_done),
      .crc_calc(crc_calc), .crc_expect(crc_expect), .init_pull(init_pull), .done_o(done_o),
      .mode_latched(mode_latched), .load_en(load_en), .io_active(io_active),
      .gsr_release(gsr_release)
   );

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_out(logic [4:0] bits, logic [MW-1:0] mode, bit chkm, string req);
      exp_t e;
      e.bits = bits; e.mode = mode; e.chk_mode = chkm; e.req = req;
      q.push_back(e);
      -> mon_ev;
   endtask

   task automatic drain();
      exp_t e;
      logic [4:0] act;
      while (q.size() > 0) begin
         e = q.pop_front();
         act = {init_pull, done_o, load_en, io_active, gsr_release};
         total++;
         if (act !== e.bits || (e.chk_mode && mode_latched !== e.mode)) begin
            bad++;
            $display("FAIL %s: outs=%b mode=%b expected outs=%b mode=%b (%0t)",
                     e.req, act, mode_latched, e.bits, e.mode, $time);
         end
      end
   endtask

   always @(mon_ev) drain();

   task automatic pulse_done();
      load_done = 1'b1;
      tick(1);
      load_done = 1'b0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
   end

   initial begin
      rst_n = 0; vcco_ok = 0; vccint_ok = 0; prog_n = 1; ext_hold = 0;
      load_done = 0; mode_pins = '0; crc_calc = '0; crc_expect = '0;
      tick(3);
      expect_out(O_PULL, 3'b000, 1, "R10 reset state");
      rst_n = 1;
      tick(4);
      expect_out(O_PULL, 3'b000, 1, "R1 no supply");
      vcco_ok = 1;
      tick(20);
      expect_out(O_PULL, 3'b000, 1, "R1 single supply only");
      vccint_ok = 1; mode_pins = 3'b101;
      tick(N);
      expect_out(O_PULL, 3'b000, 0, "R2 last clear cycle");
      tick(1);
      expect_out(O_REL, 3'b000, 0, "R3 INIT released");
      pulse_done();
      tick(1);
      expect_out(O_REL, 3'b000, 1, "R6 early load_done ignored, R3 window still shut");
      tick(1);
      expect_out(O_LOAD, 3'b101, 1, "R3 window opens, R5 mode captured");
      mode_pins = 3'b011;
      tick(3);
      expect_out(O_LOAD, 3'b101, 1, "R5 mode held");
      crc_calc = 16'hBEEF; crc_expect = 16'hBEEF;
      pulse_done();
      expect_out(O_D, 3'b101, 1, "R8 step DONE");
      tick(1);
      expect_out(O_DI, 3'b101, 1, "R8 step IO");
      tick(1);
      expect_out(O_USER, 3'b101, 1, "R8 step GSR");
      tick(5);
      expect_out(O_USER, 3'b101, 1, "R8 user operation held");

      prog_n = 0;
      tick(1);
      expect_out(O_PULL, 3'b101, 1, "R9 PROGRAM from user");
      tick(20);
      expect_out(O_PULL, 3'b101, 1, "R4 PROGRAM stretches clear");
      ext_hold = 1; prog_n = 1;
      tick(N-1);
      expect_out(O_PULL, 3'b101, 1, "R2 clear counted from PROGRAM high");
      tick(1);
      expect_out(O_REL, 3'b101, 1, "R2 clear ends");
      tick(20);
      expect_out(O_REL, 3'b101, 1, "R4 external INIT hold");
      mode_pins = 3'b010; ext_hold = 0;
      tick(2);
      expect_out(O_REL, 3'b101, 1, "R4 synchroniser delay");
      tick(1);
      expect_out(O_LOAD, 3'b010, 1, "R4 window after hold, R5 new mode");

      crc_expect = 16'hBEEE;
      pulse_done();
      expect_out(O_PULL, 3'b010, 1, "R7 CRC mismatch low lane");
      crc_expect = 16'hBEEF;
      pulse_done();
      expect_out(O_PULL, 3'b010, 1, "R7 error ignores load_done");
      tick(10);
      expect_out(O_PULL, 3'b010, 1, "R7 error held");
      prog_n = 0;
      tick(1);
      expect_out(O_PULL, 3'b010, 1, "R9 PROGRAM from error");
      prog_n = 1;
      tick(N);
      expect_out(O_REL, 3'b010, 1, "R9 recovered to release");
      tick(3);
      expect_out(O_LOAD, 3'b010, 1, "R3 window reopened");
      prog_n = 0;
      tick(1);
      expect_out(O_PULL, 3'b010, 1, "R9 PROGRAM during load");
      prog_n = 1;
      tick(N);
      expect_out(O_REL, 3'b010, 1, "R9 release after load abort");
      tick(3);
      expect_out(O_LOAD, 3'b010, 1, "R3 window again");
      pulse_done();
      tick(2);
      expect_out(O_USER, 3'b010, 1, "R8 user again");
      vccint_ok = 0;
      tick(1);
      expect_out(O_PULL, 3'b010, 1, "R9 core supply lost");
      tick(10);
      expect_out(O_PULL, 3'b010, 1, "R1 stays off without supply");
      vccint_ok = 1;
      tick(N);
      expect_out(O_PULL, 3'b010, 1, "R1 clear after supply return");
      tick(1);
      expect_out(O_REL, 3'b010, 1, "R1 release after supply return");
      tick(3);
      expect_out(O_LOAD, 3'b010, 1, "R3 window after power cycle");
      crc_expect = 16'h3EEF;
      pulse_done();
      expect_out(O_PULL, 3'b010, 1, "R7 CRC mismatch high lane");
      tick(1);
      #1;
      drain();
      summary();
   end
endmodule